// File: doc/BRIEF.md
# Read Burst Truncation Sequencer

This block sits on the controller side of a DDR SDRAM read path. Each read request from a client names a bank, a column and how many data-element pairs it needs. The block turns each request into commands on a bus that carries one command per clock. When fewer pairs are wanted than a full burst delivers, it schedules a burst stop or a precharge at the pair boundary. The data path prefetches two elements at a time, so a burst can only be shortened by whole pairs.

The sequencer also accepts write requests. It holds a write back until the read data has left the bus. It keeps a row-precharge hold counter for each bank and refuses any read or write to a bank whose hold is still running. Burst length, CAS latency and the precharge time are static configuration inputs. Requests use a ready/valid handshake, and a request is taken only in a cycle where its command can legally go out next.

Top module: `rd_trunc_seq`

## Requirements
- R1: After a synchronous active-low reset, the command bus shows NOP, and both `rd_ready` and `wr_ready` are high for every bank.
- R2: A read asking for N pairs, with 1 <= N < BL/2 and `rd_pre` low, puts READ on the bus in cycle I and BURST TERMINATE (code 3) to the same bank in cycle I+N, with no other command in between.
- R3: A pair count of 0, or of BL/2 or more, is treated as a full burst and produces no truncating command. `cfg_bl` is coded 1=BL2, 2=BL4, 3=BL8.
- R4: With `rd_pre` high and `rd_ap` low, a shortened read ends with PRECHARGE (code 4) to the read's bank in cycle I+N. With `rd_ap` high, BURST TERMINATE is used in that cycle instead.
- R5: A WRITE leaves no earlier than cycle I+N+CL after the last READ (N is the effective pair count). When nothing else blocks it, it leaves exactly in that cycle.
- R6: After a PRECHARGE to bank b in cycle p, no READ or WRITE to bank b appears before cycle p+tRP. One requested as soon as possible appears exactly at p+tRP.
- R7: A READ with auto-precharge in cycle I blocks its bank until cycle I+BL/2+tRP.
- R8: A READ with no truncation pending may follow another READ in the next cycle, cutting the earlier burst short. The write hold then counts from the newer READ.
- R9: While a truncating command is pending, no read is accepted. The earliest next READ is one cycle after that command. The truncating command always wins the bus over a read or a write.
- R10: Command codes are NOP=0, READ=1, WRITE=2. READ and WRITE carry the request's bank, column and auto-precharge flag. Every cycle without a scheduled command shows NOP, and no command appears that no request called for.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bl | input | 2 | Burst length code: 1=2, 2=4, 3=8 |
| cfg_cl | input | 2 | CAS latency in cycles (2 or 3) |
| cfg_trp | input | TRP_W | Row-precharge time in cycles |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request can be taken this cycle |
| rd_bank | input | BANK_W | Read bank |
| rd_col | input | COL_W | Read column |
| rd_pairs | input | PAIR_W | Data-element pairs wanted |
| rd_pre | input | 1 | Shorten with PRECHARGE instead of burst stop |
| rd_ap | input | 1 | READ with auto-precharge |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request can be taken this cycle |
| wr_bank | input | BANK_W | Write bank |
| wr_col | input | COL_W | Write column |
| cmd_o | output | 3 | Command code on the bus |
| cmd_bank | output | BANK_W | Command bank |
| cmd_col | output | COL_W | Command column |
| cmd_ap | output | 1 | Auto-precharge flag of the command |

## Verification
The bench uses the default parameters: four banks, a 10-bit column, a 3-bit pair count, a 4-bit tRP field and 6-bit counters. It then reprograms the configuration inputs between idle phases: BL4/CL2/tRP3, BL8/CL3/tRP2, and BL2/CL3. BL8 makes multi-cycle truncation distances reachable, together with a write gap that depends on CL3. BL2 makes every pair count a full burst, so a precharge request must produce nothing. Under BL4, the write gate and the bank hold cross each other, so a write after a precharge waits on the longer of the two.

// File: rtl/rts_pkg.sv
// Shared definitions of the read burst truncation sequencer.
// Assumes: command codes are fixed and decoded by the memory interface.
package rts_pkg;

    // Command codes placed on the command bus, one per clock.
    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_READ  = 3'd1,
        CMD_WRITE = 3'd2,
        CMD_BST   = 3'd3,
        CMD_PRE   = 3'd4
    } cmd_e;

    // Burst length configuration codes.
    localparam logic [1:0] BLC_2 = 2'd1;
    localparam logic [1:0] BLC_4 = 2'd2;
    localparam logic [1:0] BLC_8 = 2'd3;

endpackage

// File: rtl/rts_countdown.sv
// Loadable down counter that saturates at zero; used as a per-bank
// row-precharge hold and as the read-to-write gate.
// Assumes: a load wins over counting; 'idle' is high when the count is zero.
module rts_countdown #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             idle
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new hold or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // The hold has expired when the count reads zero.
    always_comb idle = (cnt_q == '0);

endmodule

// File: rtl/rts_trunc_sched.sv
// Single-slot scheduler for the command that shortens a read burst.
// Armed when a shortened READ is taken; fires when its distance has run out.
// Assumes: it is never armed while a command is pending (the top blocks reads).
module rts_trunc_sched #(
    parameter int CNT_W  = 6,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [CNT_W-1:0]  arm_dist,
    input  logic              arm_pre,
    input  logic [BANK_W-1:0] arm_bank,
    output logic              pend,
    output logic              fire,
    output logic              fire_pre,
    output logic [BANK_W-1:0] fire_bank
);

    logic [CNT_W-1:0]  dist_q;
    logic              pend_q;
    logic              pre_q;
    logic [BANK_W-1:0] bank_q;

    // Hold the pending command and count its distance down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            dist_q <= '0;
            pre_q  <= 1'b0;
            bank_q <= '0;
        end else if (arm) begin
            pend_q <= 1'b1;
            dist_q <= arm_dist;
            pre_q  <= arm_pre;
            bank_q <= arm_bank;
        end else if (fire) begin
            pend_q <= 1'b0;
        end else if (pend_q) begin
            dist_q <= dist_q - CNT_W'(1);
        end
    end

    // Fire in the cycle before the command must be on the bus.
    always_comb begin
        pend      = pend_q;
        fire      = pend_q && (dist_q == '0);
        fire_pre  = pre_q;
        fire_bank = bank_q;
    end

    AST_ARM_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> !pend_q) else $error("arm while pending"); // R9

endmodule

// File: rtl/rd_trunc_seq.sv
// Read burst truncation sequencer: takes read and write requests and issues
// READ, WRITE, BURST TERMINATE, PRECHARGE or NOP, one per clock, from a
// registered command bus.
// Assumes: configuration inputs change only while the block is idle; a request
// is taken on rd_valid&&rd_ready (or wr_valid&&wr_ready) and its command
// appears on the bus in the next cycle.
module rd_trunc_seq
    import rts_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 10,
    parameter int PAIR_W = 3,
    parameter int TRP_W  = 4,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_bl,
    input  logic [1:0]        cfg_cl,
    input  logic [TRP_W-1:0]  cfg_trp,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    input  logic [PAIR_W-1:0] rd_pairs,
    input  logic              rd_pre,
    input  logic              rd_ap,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [COL_W-1:0]  wr_col,
    output logic [2:0]        cmd_o,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_ap
);

    localparam int NUM_BANKS = 1 << BANK_W;

    // Request decode.
    logic [PAIR_W-1:0] half_pairs;
    logic              rd_full;
    logic [PAIR_W-1:0] rd_eff;
    logic              rd_short;
    logic              rd_fire;
    logic              wr_fire;

    // Timer loads.
    logic [CNT_W-1:0]  trp_hold;
    logic [CNT_W-1:0]  ap_hold;
    logic [CNT_W-1:0]  gate_val;
    logic              gate_open;
    logic [NUM_BANKS-1:0] bank_free;

    // Truncation scheduler.
    logic              t_pend;
    logic              t_fire;
    logic              t_fire_pre;
    logic [BANK_W-1:0] t_bank;

    // Next command.
    cmd_e              nxt_cmd;
    logic [BANK_W-1:0] nxt_bank;
    logic [COL_W-1:0]  nxt_col;
    logic              nxt_ap;
    cmd_e              cmd_q;

    // Burst length in pairs from the configuration code.
    always_comb begin
        case (cfg_bl)
            BLC_2:   half_pairs = PAIR_W'(1);
            BLC_4:   half_pairs = PAIR_W'(2);
            BLC_8:   half_pairs = PAIR_W'(4);
            default: half_pairs = PAIR_W'(1);
        endcase
    end

    // Effective pair count: out-of-range counts mean a full burst.
    always_comb begin
        rd_full  = (rd_pairs == '0) || (rd_pairs >= half_pairs);
        rd_eff   = rd_full ? half_pairs : rd_pairs;
        rd_short = !rd_full;
    end

    // Hold lengths for the bank timers and the write gate.
    always_comb begin
        trp_hold = (cfg_trp == '0) ? '0 : CNT_W'(cfg_trp - TRP_W'(1));
        ap_hold  = CNT_W'(half_pairs) + trp_hold;
        gate_val = CNT_W'(rd_eff) + CNT_W'(cfg_cl) - CNT_W'(1);
    end

    // Request acceptance: the truncating command owns the bus, reads beat writes.
    always_comb begin
        rd_ready = !t_pend && bank_free[rd_bank];
        rd_fire  = rd_valid && rd_ready;
        wr_ready = !t_pend && gate_open && bank_free[wr_bank] && !rd_fire;
        wr_fire  = wr_valid && wr_ready;
    end

    rts_trunc_sched #(
        .CNT_W (CNT_W),
        .BANK_W(BANK_W)
    ) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (rd_fire && rd_short),
        .arm_dist (CNT_W'(rd_eff) - CNT_W'(1)),
        .arm_pre  (rd_pre && !rd_ap),
        .arm_bank (rd_bank),
        .pend     (t_pend),
        .fire     (t_fire),
        .fire_pre (t_fire_pre),
        .fire_bank(t_bank)
    );

    rts_countdown #(.CNT_W(CNT_W)) u_wr_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (rd_fire),
        .load_val(gate_val),
        .idle    (gate_open)
    );

    // One precharge hold timer per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic             ld;
        logic [CNT_W-1:0] ld_val;

        // Load on an explicit precharge or on an auto-precharge READ.
        always_comb begin
            ld     = 1'b0;
            ld_val = trp_hold;
            if (t_fire && t_fire_pre && (t_bank == BANK_W'(b))) begin
                ld = 1'b1;
            end else if (rd_fire && rd_ap && (rd_bank == BANK_W'(b))) begin
                ld     = 1'b1;
                ld_val = ap_hold;
            end
        end

        rts_countdown #(.CNT_W(CNT_W)) u_hold (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (ld),
            .load_val(ld_val),
            .idle    (bank_free[b])
        );
    end

    // Pick the command for the next bus cycle.
    always_comb begin
        nxt_cmd  = CMD_NOP;
        nxt_bank = '0;
        nxt_col  = '0;
        nxt_ap   = 1'b0;
        if (t_fire) begin
            nxt_cmd  = t_fire_pre ? CMD_PRE : CMD_BST;
            nxt_bank = t_bank;
        end else if (rd_fire) begin
            nxt_cmd  = CMD_READ;
            nxt_bank = rd_bank;
            nxt_col  = rd_col;
            nxt_ap   = rd_ap;
        end else if (wr_fire) begin
            nxt_cmd  = CMD_WRITE;
            nxt_bank = wr_bank;
            nxt_col  = wr_col;
        end
    end

    // Register the command bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= CMD_NOP;
            cmd_bank <= '0;
            cmd_col  <= '0;
            cmd_ap   <= 1'b0;
        end else begin
            cmd_q    <= nxt_cmd;
            cmd_bank <= nxt_bank;
            cmd_col  <= nxt_col;
            cmd_ap   <= nxt_ap;
        end
    end

    always_comb cmd_o = cmd_q;

    // ---- Observation of the bus for the checks below ----
    logic [CNT_W-1:0]  since_rd;
    logic [PAIR_W-1:0] last_n;
    logic              last_ap;
    logic              seen_rd;

    // Track the age of the most recent READ and its pair count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rd <= '0;
            last_n   <= '0;
            last_ap  <= 1'b0;
            seen_rd  <= 1'b0;
        end else if (rd_fire) begin
            since_rd <= '0;
            last_n   <= rd_eff;
            last_ap  <= rd_ap;
            seen_rd  <= 1'b1;
        end else if (since_rd != '1) begin
            since_rd <= since_rd + CNT_W'(1);
        end
    end

    AST_BST_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_BST) |-> (seen_rd && since_rd == CNT_W'(last_n)))
        else $error("burst stop off pair boundary"); // R2

    AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PRE) |-> (seen_rd && since_rd == CNT_W'(last_n) && !last_ap))
        else $error("precharge truncation misplaced"); // R4

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_WRITE && seen_rd) |->
            ({1'b0, since_rd} >= ({1'b0, CNT_W'(last_n)} + (CNT_W+1)'(cfg_cl))))
        else $error("write during read burst"); // R5

    AST_TRP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PRE && cfg_trp > TRP_W'(1)) |=>
            !((cmd_q == CMD_READ || cmd_q == CMD_WRITE) && cmd_bank == $past(cmd_bank)))
        else $error("bank used inside tRP"); // R6

endmodule

// File: tb/rd_trunc_seq_test.sv
// Scoreboard bench: driver tasks predict the command stream into a queue,
// a monitor pops and compares each command seen on the bus.
module rd_trunc_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_bl = 2'd2;
    logic [1:0]  cfg_cl = 2'd2;
    logic [3:0]  cfg_trp = 4'd3;
    logic        rd_valid = 1'b0;
    logic        rd_ready;
    logic [1:0]  rd_bank = '0;
    logic [9:0]  rd_col = '0;
    logic [2:0]  rd_pairs = '0;
    logic        rd_pre = 1'b0;
    logic        rd_ap = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [1:0]  wr_bank = '0;
    logic [9:0]  wr_col = '0;
    logic [2:0]  cmd_o;
    logic [1:0]  cmd_bank;
    logic [9:0]  cmd_col;
    logic        cmd_ap;

    rd_trunc_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_bl(cfg_bl), .cfg_cl(cfg_cl), .cfg_trp(cfg_trp),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_bank(rd_bank), .rd_col(rd_col),
        .rd_pairs(rd_pairs), .rd_pre(rd_pre), .rd_ap(rd_ap),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_bank(wr_bank), .wr_col(wr_col),
        .cmd_o(cmd_o), .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_ap(cmd_ap)
    );

    always #10 clk = ~clk; // 50 MHz

    typedef struct {
        int         cyc;
        logic [2:0] cmd;
        logic [1:0] bank;
        logic [9:0] col;
        logic       ap;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    bit   mon_on = 1'b0;

    // Model state: earliest bus cycles.
    int bank_ok[4] = '{0, 0, 0, 0};
    int t_trunc = -10;
    int t_wr = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Monitor: compare every non-NOP command with the head of the queue.
    always @(negedge clk) begin
        if (mon_on && rst_n && cmd_o != 3'd0) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected command code", int'(cmd_o), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(cmd_o == e.cmd, e.tag, "command code", int'(cmd_o), int'(e.cmd));
                check(cyc == e.cyc, e.tag, "command cycle", cyc, e.cyc);
                check(cmd_bank == e.bank && cmd_col == e.col && cmd_ap == e.ap, e.tag,
                      "bank/col/ap", int'({cmd_bank, cmd_col, cmd_ap}),
                      int'({e.bank, e.col, e.ap}));
            end
        end
    end

    task automatic push(input int c, input logic [2:0] k, input logic [1:0] b,
                        input logic [9:0] col, input logic ap, input string tag);
        exp_t e;
        e.cyc = c; e.cmd = k; e.bank = b; e.col = col; e.ap = ap; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Read driver: predict READ and any truncating command, then handshake.
    task automatic do_read(input logic [1:0] b, input logic [9:0] col, input logic [2:0] pairs,
                           input logic pre, input logic ap, input string rtag, input string ttag);
        int half = 1 << (int'(cfg_bl) - 1);
        bit full = (pairs == 0) || (int'(pairs) >= half);
        int n = full ? half : int'(pairs);
        int i = imax(imax(cyc + 1, bank_ok[b]), t_trunc + 1);
        push(i, 3'd1, b, col, ap, rtag);
        if (!full) begin
            push(i + n, (pre && !ap) ? 3'd4 : 3'd3, b, 10'd0, 1'b0, ttag);
            t_trunc = i + n;
            if (pre && !ap) bank_ok[b] = i + n + int'(cfg_trp);
        end
        if (ap) bank_ok[b] = i + half + int'(cfg_trp);
        t_wr = i + n + int'(cfg_cl);
        rd_bank = b; rd_col = col; rd_pairs = pairs; rd_pre = pre; rd_ap = ap;
        rd_valid = 1'b1;
        for (int g = 0; g < 100 && !rd_ready; g++) @(negedge clk);
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    // Write driver: predict the earliest legal WRITE, then handshake.
    task automatic do_write(input logic [1:0] b, input logic [9:0] col, input string tag);
        int w = imax(imax(cyc + 1, t_wr), imax(bank_ok[b], t_trunc + 1));
        push(w, 3'd2, b, col, 1'b0, tag);
        wr_bank = b; wr_col = col; wr_valid = 1'b1;
        for (int g = 0; g < 100 && !wr_ready; g++) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(cmd_o == 3'd0, "R1", "cmd after reset", int'(cmd_o), 0);
        check(rd_ready == 1'b1, "R1", "rd_ready after reset", int'(rd_ready), 1);
        check(wr_ready == 1'b1, "R1", "wr_ready after reset", int'(wr_ready), 1);
        mon_on = 1'b1;

        // BL4, CL2, tRP3
        do_read(2'd0, 10'd5, 3'd1, 1'b0, 1'b0, "R10", "R2");     // stop after one pair
        do_write(2'd1, 10'd9, "R5");                             // waits I+1+CL
        settle(4);
        do_read(2'd2, 10'd17, 3'd2, 1'b0, 1'b0, "R3", "R3");     // full burst
        do_write(2'd0, 10'd33, "R3");
        settle(4);
        do_read(2'd1, 10'd40, 3'd0, 1'b0, 1'b0, "R3", "R3");     // zero pairs = full
        do_read(2'd3, 10'd41, 3'd5, 1'b0, 1'b0, "R8", "R3");     // cuts previous read
        do_write(2'd2, 10'd50, "R8");
        settle(4);
        do_read(2'd2, 10'd60, 3'd1, 1'b1, 1'b0, "R4", "R4");     // precharge truncation
        do_read(2'd2, 10'd61, 3'd2, 1'b0, 1'b0, "R6", "R3");     // same bank after tRP
        settle(4);
        do_read(2'd1, 10'd70, 3'd1, 1'b1, 1'b0, "R4", "R4");
        do_write(2'd1, 10'd71, "R6");                            // bank hold beats gate
        settle(4);
        do_read(2'd3, 10'd80, 3'd2, 1'b0, 1'b1, "R7", "R3");     // auto-precharge
        do_read(2'd3, 10'd81, 3'd2, 1'b0, 1'b0, "R7", "R3");
        settle(4);
        do_read(2'd0, 10'd90, 3'd1, 1'b1, 1'b1, "R4", "R4");     // ap forces burst stop
        settle(20);

        // BL8, CL3, tRP2
        cfg_bl = 2'd3; cfg_cl = 2'd3; cfg_trp = 4'd2;
        settle(2);
        do_read(2'd0, 10'd100, 3'd3, 1'b0, 1'b0, "R2", "R2");
        do_read(2'd1, 10'd101, 3'd4, 1'b0, 1'b0, "R9", "R3");    // waits for stop
        do_write(2'd1, 10'd102, "R5");
        settle(4);
        do_read(2'd2, 10'd110, 3'd2, 1'b1, 1'b0, "R4", "R4");
        do_write(2'd2, 10'd111, "R6");
        settle(20);

        // BL2, CL3: every count is a full burst
        cfg_bl = 2'd1;
        settle(2);
        do_read(2'd3, 10'd120, 3'd1, 1'b1, 1'b0, "R3", "R3");
        do_write(2'd0, 10'd121, "R5");
        settle(30);

        check(exp_q.size() == 0, "R10", "commands still expected", exp_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule